// File: doc/BRIEF.md
# Cascaded Interrupt Controller With Polling

This block gathers sixteen interrupt request lines into two eight-input priority controllers. The secondary controller's request output drives input 2 of the primary, so lines 8 to 15 compete as one group at the priority of primary input 2. One interrupt line goes to the host. Software services requests by polling over a small byte-wide host port, not through a vectored acknowledge cycle.

Through the host port, software writes a mask byte for each controller and two trigger-mode bytes. It issues commands to either controller: poll, specific end-of-interrupt, select which register later reads return, and special mask mode. A poll that finds a winner marks that input in service and retires its request. Software then polls the secondary if the primary reported the cascade input. When it is done, it sends a specific end-of-interrupt to the secondary and then level 2 to the primary.

Top module: `cascade_irq_ctl`

## Requirements
- R1: After reset both mask bytes read 0xFF, both trigger bytes read 0x00, both data addresses read 0x00, and host_irq is low.
- R2: Trigger bytes live at address 2 (lines 0–7) and address 3 (lines 8–15) and read back as written. A 1 makes a line level-sensitive: its request follows the input while the line is not in service, it returns after end-of-interrupt if the input is still high, and it vanishes when the input drops.
- R3: Bit 2 of the primary mask byte (address 0) reads 0 when any bit of the secondary mask byte (address 1) is 0, and reads 1 when the secondary mask is 0xFF. Host writes to that bit have no effect.
- R4: Writing the poll command 0x20 to a controller's command address (4 primary, 5 secondary) makes the next read of that address return {pending, 4'b0, input[2:0]}. When nothing is pending the value is 0x00 and no in-service bit changes. This covers a request that vanished, which is not treated as a line-7 event.
- R5: Within a controller input 0 has the highest priority and input 7 the lowest. Lines 8–15 take the priority of primary input 2, so line 9 beats line 3.
- R6: An edge-sensitive line latches its request on a rising input and holds it, even after the input falls, until a poll reports it. A reporting poll sets that input's in-service bit and clears its request bit.
- R7: When the primary's poll reports input 2, polling the secondary returns the winning secondary input, and the line number is that input plus 8.
- R8: Command 0x10|level is a specific end-of-interrupt. It clears only that level's in-service bit and never sets one.
- R9: Command 0x30 selects the request register and 0x31 the in-service register for later data reads. After reset the request register is selected.
- R10: Normally an in-service input blocks equal and lower priority requests, and host_irq stays low. After command 0x41 (special mask mode on; 0x40 turns it off), in-service inputs that are masked block nothing.
- R11: host_irq is high exactly when the primary holds an unmasked request that no in-service input blocks.
- R12: A masked line still latches its request, visible in the request register, but no poll reports it and it does not raise host_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 16 | Request lines 0–15; line 2 has no external source |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe; retires a pending poll result |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
Two functions can act on the same input at the same clock edge: a specific end-of-interrupt and the request tracking of a level-sensitive line. The bench provokes this by holding line 0 high in level mode, polling it, and then sending its end-of-interrupt while the input stays high. Right after that edge, reading the request register must show bit 0 set again, and it must clear once the input drops. The bench also polls while an in-service input is blocking a lower request, with and without special mask mode. It judges both the returned poll byte and the unchanged in-service register.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam int BYTE_W  = 8;
   localparam int HOST_AW = 3;

   // upper nibble of a command byte
   typedef enum logic [3:0] {
      OP_EOI  = 4'h1,
      OP_POLL = 4'h2,
      OP_RSEL = 4'h3,
      OP_SMM  = 4'h4
   } cic_op_e;

   typedef enum logic [HOST_AW-1:0] {
      RA_PMASK  = 3'd0,
      RA_SMASK  = 3'd1,
      RA_TRIGLO = 3'd2,
      RA_TRIGHI = 3'd3,
      RA_PCTL   = 3'd4,
      RA_SCTL   = 3'd5
   } cic_addr_e;

   typedef struct packed {
      logic       eoi;
      logic       poll;
      logic       rsel;
      logic       smm;
      logic [2:0] lvl;
      logic       arg;
   } cic_cmd_t;

   function automatic cic_cmd_t cic_decode(input logic en, input logic [BYTE_W-1:0] b);
      cic_cmd_t c;
      c.eoi  = en && (b[7:4] == OP_EOI);
      c.poll = en && (b[7:4] == OP_POLL);
      c.rsel = en && (b[7:4] == OP_RSEL);
      c.smm  = en && (b[7:4] == OP_SMM);
      c.lvl  = b[2:0];
      c.arg  = b[0];
      return c;
   endfunction
endpackage

// File: rtl/cic_prio.sv
// Lowest-index set bit finder: index 0 is the highest priority.
module cic_prio #(
   parameter int N = 8
) (
   input  logic [N-1:0]         vec,
   output logic                 found,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IW = $clog2(N);

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/cic_unit.sv
// One eight-input priority controller: request/in-service state, poll, EOI.
module cic_unit
   import cic_pkg::*;
#(
   parameter int N_IN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IN-1:0]   req_in,
   input  logic [N_IN-1:0]   level_sel,
   input  logic [N_IN-1:0]   mask,
   input  cic_cmd_t          cmd,
   input  logic              rd_take,
   output logic              int_out,
   output logic [BYTE_W-1:0] rdata
);
   localparam int IW = $clog2(N_IN);

   logic [N_IN-1:0] irr_q, isr_q, prev_q;
   logic [N_IN-1:0] irr_d, isr_d, ack, eoi_clr, cand, blk;
   logic            smm_q, sel_isr_q, pflag_q;
   logic [BYTE_W-1:0] pbyte_q, pbyte_d;
   logic            c_v, b_v, pending;
   logic [IW-1:0]   c_idx, b_idx;

   assign cand = irr_q & ~mask;
   assign blk  = smm_q ? (isr_q & ~mask) : isr_q;

   cic_prio #(.N(N_IN)) u_win (.vec(cand), .found(c_v), .idx(c_idx));
   cic_prio #(.N(N_IN)) u_blk (.vec(blk),  .found(b_v), .idx(b_idx));

   assign pending = c_v && (!b_v || (c_idx < b_idx));
   assign int_out = pending;

   always_comb begin
      ack     = (cmd.poll && pending) ? (N_IN'(1) << c_idx) : '0;
      eoi_clr = cmd.eoi ? (N_IN'(1) << cmd.lvl) : '0;
      isr_d   = (isr_q | ack) & ~eoi_clr;
      pbyte_d = pending ? {1'b1, 4'b0000, 3'(c_idx)} : '0;
   end

   for (genvar g = 0; g < N_IN; g++) begin : g_line
      always_comb begin
         if (level_sel[g]) irr_d[g] = req_in[g] & ~isr_d[g];
         else              irr_d[g] = (irr_q[g] | (req_in[g] & ~prev_q[g])) & ~ack[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q     <= '0;
         isr_q     <= '0;
         prev_q    <= '0;
         smm_q     <= 1'b0;
         sel_isr_q <= 1'b0;
         pflag_q   <= 1'b0;
         pbyte_q   <= '0;
      end else begin
         prev_q <= req_in;
         irr_q  <= irr_d;
         isr_q  <= isr_d;
         if (cmd.poll) begin
            pflag_q <= 1'b1;
            pbyte_q <= pbyte_d;
         end else if (rd_take) begin
            pflag_q <= 1'b0;
         end
         if (cmd.rsel) sel_isr_q <= cmd.arg;
         if (cmd.smm)  smm_q     <= cmd.arg;
      end
   end

   always_comb begin
      if (pflag_q)        rdata = pbyte_q;
      else if (sel_isr_q) rdata = BYTE_W'(isr_q);
      else                rdata = BYTE_W'(irr_q);
   end
endmodule

// File: rtl/cascade_irq_ctl.sv
// Primary/secondary controller pair with host register port.
module cascade_irq_ctl
   import cic_pkg::*;
#(
   parameter int N_IN    = 8,
   parameter int CASC_IN = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*N_IN-1:0]   irq_lines,
   input  logic [HOST_AW-1:0]  host_addr,
   input  logic                host_wr,
   input  logic [BYTE_W-1:0]   host_wdata,
   input  logic                host_rd,
   output logic [BYTE_W-1:0]   host_rdata,
   output logic                host_irq
);
   localparam int LINES = 2 * N_IN;

   if (N_IN < 2 || N_IN > 8)          begin : g_bad_n    $error("N_IN must be 2..8");        end
   if (CASC_IN < 0 || CASC_IN >= N_IN) begin : g_bad_casc $error("CASC_IN out of range");    end

   logic [N_IN-1:0]  pmask_q, smask_q, p_mask_eff, p_req, p_level;
   logic [LINES-1:0] trig_q;
   logic             s_int, p_int;
   logic [BYTE_W-1:0] p_rdata, s_rdata;
   cic_cmd_t         p_cmd, s_cmd;
   cic_addr_e        ra;
   logic             unused_casc_pin;

   assign ra              = cic_addr_e'(host_addr);
   assign unused_casc_pin = irq_lines[CASC_IN];

   always_comb begin
      p_cmd = cic_decode(host_wr && (ra == RA_PCTL), host_wdata);
      s_cmd = cic_decode(host_wr && (ra == RA_SCTL), host_wdata);
      p_mask_eff          = pmask_q;
      p_mask_eff[CASC_IN] = &smask_q;
      p_req               = irq_lines[N_IN-1:0];
      p_req[CASC_IN]      = s_int;
      p_level             = trig_q[N_IN-1:0];
      p_level[CASC_IN]    = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pmask_q <= '1;
         smask_q <= '1;
         trig_q  <= '0;
      end else if (host_wr) begin
         case (ra)
            RA_PMASK:  pmask_q             <= host_wdata[N_IN-1:0];
            RA_SMASK:  smask_q             <= host_wdata[N_IN-1:0];
            RA_TRIGLO: trig_q[N_IN-1:0]    <= host_wdata[N_IN-1:0];
            RA_TRIGHI: trig_q[LINES-1:N_IN] <= host_wdata[N_IN-1:0];
            default: ;
         endcase
      end
   end

   cic_unit #(.N_IN(N_IN)) u_sec (
      .clk(clk), .rst_n(rst_n),
      .req_in(irq_lines[LINES-1:N_IN]), .level_sel(trig_q[LINES-1:N_IN]),
      .mask(smask_q), .cmd(s_cmd), .rd_take(host_rd && (ra == RA_SCTL)),
      .int_out(s_int), .rdata(s_rdata)
   );

   cic_unit #(.N_IN(N_IN)) u_pri (
      .clk(clk), .rst_n(rst_n),
      .req_in(p_req), .level_sel(p_level),
      .mask(p_mask_eff), .cmd(p_cmd), .rd_take(host_rd && (ra == RA_PCTL)),
      .int_out(p_int), .rdata(p_rdata)
   );

   assign host_irq = p_int;

   always_comb begin
      case (ra)
         RA_PMASK:  host_rdata = BYTE_W'(p_mask_eff);
         RA_SMASK:  host_rdata = BYTE_W'(smask_q);
         RA_TRIGLO: host_rdata = BYTE_W'(trig_q[N_IN-1:0]);
         RA_TRIGHI: host_rdata = BYTE_W'(trig_q[LINES-1:N_IN]);
         RA_PCTL:   host_rdata = p_rdata;
         RA_SCTL:   host_rdata = s_rdata;
         default:   host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cic_checkers.sv
module cic_unit_chk #(
   parameter int N_IN = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            poll,
   input logic            eoi,
   input logic            int_out,
   input logic [N_IN-1:0] isr,
   input logic [N_IN-1:0] irr,
   input logic [N_IN-1:0] mask
);
   // R6: a reporting poll adds exactly one in-service bit
   a_r6_poll_adds_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (poll && int_out) |=> ($countones(isr) == $countones($past(isr)) + 1));
   // R4: an empty poll leaves in-service state untouched
   a_r4_empty_poll_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (poll && !int_out) |=> $stable(isr));
   // R8: end-of-interrupt never creates an in-service bit
   a_r8_eoi_no_new_isr: assert property (@(posedge clk) disable iff (!rst_n)
      eoi |=> ((isr & ~$past(isr)) == '0));
   // R11 / R12: a request output needs an unmasked request
   a_r11_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((irr & ~mask) != '0));
endmodule

module cic_top_chk #(
   parameter int N_IN    = 8,
   parameter int CASC_IN = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      host_addr,
   input logic [7:0]      host_rdata,
   input logic [N_IN-1:0] smask
);
   // R3: cascade mask bit tracks the secondary mask
   a_r3_cascade_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == 3'd0) |-> (host_rdata[CASC_IN] == (&smask)));
endmodule

bind cic_unit cic_unit_chk #(.N_IN(N_IN)) u_unit_chk (
   .clk(clk), .rst_n(rst_n), .poll(cmd.poll), .eoi(cmd.eoi),
   .int_out(int_out), .isr(isr_q), .irr(irr_q), .mask(mask)
);

bind cascade_irq_ctl cic_top_chk #(.N_IN(N_IN), .CASC_IN(CASC_IN)) u_top_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
   .host_rdata(host_rdata), .smask(smask_q)
);

// File: tb/cascade_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module cascade_irq_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq = '0;
   logic [2:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        host_irq;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   typedef struct { logic [7:0] exp; string tag; } exp_t;
   exp_t       exp_q[$];
   logic [7:0] act_q[$];

   always #4 clk = ~clk;

   cascade_irq_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq), .host_addr(addr),
      .host_wr(wr), .host_wdata(wdata), .host_rd(rd),
      .host_rdata(rdata), .host_irq(host_irq)
   );

   // scoreboard monitor
   always @(posedge clk) begin
      while (act_q.size() > 0 && exp_q.size() > 0) begin
         exp_t e;
         logic [7:0] a;
         e = exp_q.pop_front();
         a = act_q.pop_front();
         checks++;
         if (a !== e.exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", e.tag, a, e.exp);
         end
      end
   end

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_expect(input logic [2:0] a, input logic [7:0] e, input string tag);
      @(negedge clk); addr = a; rd = 1'b1;
      exp_q.push_back('{e, tag});
      #2 act_q.push_back(rdata);
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk); #2;
      checks++;
      if (host_irq !== e) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", tag, host_irq, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic line(input int i, input logic v);
      @(negedge clk); irq[i] = v;
      idle(3);
   endtask

   task automatic poll(input logic [2:0] a, input logic [7:0] e, input string tag);
      wr_reg(a, 8'h20);
      rd_expect(a, e, tag);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      rd_expect(3'd0, 8'hFF, "R1 primary mask");
      rd_expect(3'd1, 8'hFF, "R1 secondary mask");
      rd_expect(3'd2, 8'h00, "R1 trigger low");
      rd_expect(3'd3, 8'h00, "R1 trigger high");
      rd_expect(3'd4, 8'h00, "R1 R9 primary request reg");
      rd_expect(3'd5, 8'h00, "R1 secondary request reg");
      chk_irq(1'b0, "R1 host_irq");

      // R3 cascade mask
      wr_reg(3'd1, 8'hFD);
      rd_expect(3'd0, 8'hFB, "R3 cascade unmasked");
      wr_reg(3'd0, 8'hFF);
      rd_expect(3'd0, 8'hFB, "R3 bit 2 write ignored");
      wr_reg(3'd1, 8'hFF);
      rd_expect(3'd0, 8'hFF, "R3 cascade masked");
      wr_reg(3'd0, 8'h00);
      rd_expect(3'd0, 8'h04, "R3 bit 2 held by secondary");

      // R12 masked line, then R7 cascade service
      line(10, 1'b1);
      chk_irq(1'b0, "R12 masked no irq");
      rd_expect(3'd5, 8'h04, "R12 masked request latched");
      poll(3'd5, 8'h00, "R12 masked not polled");
      rd_expect(3'd5, 8'h04, "R12 request kept");
      wr_reg(3'd1, 8'hFB);
      idle(3);
      chk_irq(1'b1, "R11 cascade irq");
      poll(3'd4, 8'h82, "R7 primary reports cascade");
      poll(3'd5, 8'h82, "R7 secondary input 2 line 10");
      wr_reg(3'd5, 8'h31);
      rd_expect(3'd5, 8'h04, "R9 secondary in-service");
      wr_reg(3'd5, 8'h12);
      rd_expect(3'd5, 8'h00, "R8 secondary EOI");
      wr_reg(3'd5, 8'h30);
      wr_reg(3'd4, 8'h12);
      wr_reg(3'd4, 8'h31);
      rd_expect(3'd4, 8'h00, "R8 primary EOI cascade");
      wr_reg(3'd4, 8'h30);
      line(10, 1'b0);
      wr_reg(3'd1, 8'hFF);

      // R5 R6 R10 priority and blocking
      line(5, 1'b1);
      line(3, 1'b1);
      chk_irq(1'b1, "R11 pending irq");
      rd_expect(3'd4, 8'h28, "R6 two requests latched");
      poll(3'd4, 8'h83, "R5 line 3 beats 5");
      rd_expect(3'd4, 8'h20, "R6 request cleared");
      wr_reg(3'd4, 8'h31);
      rd_expect(3'd4, 8'h08, "R9 R6 in-service set");
      chk_irq(1'b0, "R10 lower request blocked");
      poll(3'd4, 8'h00, "R10 blocked poll");
      rd_expect(3'd4, 8'h08, "R4 empty poll keeps in-service");
      wr_reg(3'd4, 8'h13);
      rd_expect(3'd4, 8'h00, "R8 EOI level 3");
      chk_irq(1'b1, "R11 unblocked");
      poll(3'd4, 8'h85, "R6 line 5 held");
      wr_reg(3'd4, 8'h15);
      line(3, 1'b0);
      line(5, 1'b0);

      // R5 secondary group priority
      wr_reg(3'd1, 8'hFD);
      line(3, 1'b1);
      line(9, 1'b1);
      poll(3'd4, 8'h82, "R5 line 9 beats line 3");
      poll(3'd5, 8'h81, "R7 secondary input 1 line 9");
      wr_reg(3'd5, 8'h11);
      wr_reg(3'd4, 8'h12);
      poll(3'd4, 8'h83, "R5 line 3 next");
      wr_reg(3'd4, 8'h13);
      wr_reg(3'd1, 8'hFF);
      line(3, 1'b0);
      line(9, 1'b0);

      // R8 nested in-service, specific EOI
      line(6, 1'b1);
      poll(3'd4, 8'h86, "R5 line 6");
      line(1, 1'b1);
      poll(3'd4, 8'h81, "R10 higher preempts");
      rd_expect(3'd4, 8'h42, "R8 two in service");
      wr_reg(3'd4, 8'h16);
      rd_expect(3'd4, 8'h02, "R8 only level 6 cleared");
      wr_reg(3'd4, 8'h11);
      rd_expect(3'd4, 8'h00, "R8 level 1 cleared");

      // R10 special mask mode
      line(4, 1'b1);
      poll(3'd4, 8'h84, "R10 line 4");
      wr_reg(3'd0, 8'h10);
      line(7, 1'b1);
      poll(3'd4, 8'h00, "R10 normal mode blocks");
      wr_reg(3'd4, 8'h41);
      poll(3'd4, 8'h87, "R10 special mask passes");
      rd_expect(3'd4, 8'h90, "R10 in-service both");
      wr_reg(3'd4, 8'h17);
      wr_reg(3'd4, 8'h14);
      wr_reg(3'd4, 8'h40);
      wr_reg(3'd0, 8'h00);
      rd_expect(3'd4, 8'h00, "R8 all cleared");

      // R2 trigger bytes and level behaviour
      wr_reg(3'd2, 8'h01);
      rd_expect(3'd2, 8'h01, "R2 trigger low");
      wr_reg(3'd3, 8'h80);
      rd_expect(3'd3, 8'h80, "R2 trigger high");
      wr_reg(3'd3, 8'h00);
      wr_reg(3'd4, 8'h30);
      line(0, 1'b1);
      poll(3'd4, 8'h80, "R2 level line 0");
      wr_reg(3'd4, 8'h10);
      idle(2);
      rd_expect(3'd4, 8'h01, "R2 level returns after EOI");
      line(0, 1'b0);
      rd_expect(3'd4, 8'h00, "R2 level follows input");
      poll(3'd4, 8'h00, "R4 vanished request empty");
      wr_reg(3'd4, 8'h31);
      rd_expect(3'd4, 8'h00, "R4 no spurious in-service");
      wr_reg(3'd4, 8'h30);
      line(3, 1'b1);
      line(3, 1'b0);
      rd_expect(3'd4, 8'h08, "R6 edge held after drop");
      poll(3'd4, 8'h83, "R6 edge serviced");
      wr_reg(3'd4, 8'h13);

      idle(4);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule